// File: doc/BRIEF.md
# Near Control-Transfer Sequencer

This block works out where a simple 32-bit execution core goes next after a near control-transfer operation, and how its stack pointer moves. The decoder supplies an operation kind, the address of the following instruction, a displacement, an optional return byte count, an indirect target source and the current stack pointer. The block then issues any needed stack or target accesses on a single-beat 32-bit data-memory port. When the last access completes, it returns the new instruction pointer and the new stack pointer with a one-cycle done pulse.

Relative branches come in a short form, which uses an 8-bit signed displacement, and a long form, which uses a 32-bit signed displacement. An external flag evaluator supplies the condition-true input for conditional branches. Calls push the return address to memory. Returns pop the return address and then release extra caller-specified stack bytes. A separate combinational path sorts a software-interrupt vector into the processor-reserved range or the software-defined range.

Top module: `nct_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `mem_req` are low.
- R2: With `op_long`=0, a relative operation computes `next_ip` plus the sign-extended low 8 bits of `op_disp`. Bits 31..8 of `op_disp` have no effect.
- R3: With `op_long`=1, a relative operation computes `next_ip` plus the full 32-bit `op_disp`, wrapping modulo 2^32.
- R4: A conditional branch (`op_kind`=0) goes to the relative target only when `cond_true`=1. Otherwise it goes to `next_ip`. An unconditional relative jump (`op_kind`=1) is taken whatever `cond_true` is. Neither changes the stack pointer.
- R5: An indirect jump (`op_kind`=2) goes to `ind_reg` when `ind_from_mem`=0. When `ind_from_mem`=1 it goes to the word read from `ind_addr`. The stack pointer is unchanged.
- R6: A call (`op_kind`=3 relative, `op_kind`=4 indirect) writes `next_ip` to address `sp_in`-4. It reports `new_sp`=`sp_in`-4, and `new_ip` is the call target.
- R7: An indirect call with `ind_from_mem`=1 reads the target from `ind_addr` before it performs the push. The read therefore returns the old memory contents even when `ind_addr` equals `sp_in`-4.
- R8: A return (`op_kind`=5) reads the word at `sp_in` as `new_ip`. It reports `new_sp` = `sp_in` + 4 + the zero-extended 16-bit `ret_imm`. A zero `ret_imm` gives an adjustment of exactly 4.
- R9: `done` is a single-cycle pulse that follows the completion of every memory access of the operation. `busy` stays high from acceptance through `done`. `op_valid` has no effect while `busy` is high. Each accepted operation gives exactly one `done`.
- R10: `vec_reserved` is high for `int_vector` 0 to 31. `vec_user` is high for 32 to 255. Exactly one of the two is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request, accepted when not busy |
| op_kind | input | 3 | 0 cond branch, 1 rel jump, 2 ind jump, 3 rel call, 4 ind call, 5 return |
| op_long | input | 1 | 1 selects the 32-bit displacement |
| op_disp | input | 32 | Relative displacement |
| ret_imm | input | 16 | Extra stack bytes released by a return |
| next_ip | input | 32 | Address of the following instruction |
| cond_true | input | 1 | Condition result from the flag evaluator |
| ind_from_mem | input | 1 | Indirect target comes from memory |
| ind_reg | input | 32 | Register indirect target |
| ind_addr | input | 32 | Memory address of the indirect target |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| new_ip | output | 32 | Next instruction pointer |
| new_sp | output | 32 | Next stack pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes on this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| int_vector | input | 8 | Software-interrupt vector to classify |
| vec_reserved | output | 1 | Vector is processor-reserved |
| vec_user | output | 1 | Vector is software-defined |

## Verification
The short-form branch is exercised over every 8-bit displacement, with the condition both true and false and with junk in the upper displacement bits. This separates correct sign extension and the not-taken path from a zero or one extension. Long displacements are chosen so that the sum crosses zero in both directions, which exposes any truncation. Returns are tested across the whole 16-bit immediate range, and every vector is classified, which catches off-by-one errors at the 31/32 boundary. Indirect calls whose target word shares the push slot show whether the read is ordered before the push. A request raised while busy shows whether the block starts a second operation.

// File: rtl/nct_pkg.sv
// Shared types for the near control-transfer sequencer.
// Assumes op_kind encodings are fixed by the decoder (values 6 and 7 unused).
package nct_pkg;
    typedef enum logic [2:0] {
        OP_JCC      = 3'd0,
        OP_JMP_REL  = 3'd1,
        OP_JMP_IND  = 3'd2,
        OP_CALL_REL = 3'd3,
        OP_CALL_IND = 3'd4,
        OP_RET      = 3'd5
    } nct_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_TGT,
        ST_PUSH,
        ST_POP,
        ST_FIN
    } nct_state_e;
endpackage

// File: rtl/nct_addr_calc.sv
// Address arithmetic: relative target, stack pointer after a push and after
// a pop with extra release. Purely combinational; all sums wrap modulo 2^ADDR_W.
module nct_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int SHORT_W    = 8,
    parameter int IMM_W      = 16,
    parameter int SLOT_BYTES = 4
) (
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [ADDR_W-1:0] disp,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] rel_tgt,
    output logic [ADDR_W-1:0] sp_dec,
    output logic [ADDR_W-1:0] sp_ret
);
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_BYTES);

    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] imm_ext;

    generate
        if (SHORT_W < ADDR_W) begin : g_sext
            assign short_ext = {{(ADDR_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end else begin : g_nosext
            assign short_ext = disp;
        end
        if (IMM_W < ADDR_W) begin : g_zext
            assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[ADDR_W-1:0];
        end
    endgenerate

    // Select the displacement form and form the three sums.
    always_comb begin
        rel_tgt = next_ip + (is_long ? disp : short_ext);
        sp_dec  = sp_in - SLOT;
        sp_ret  = sp_in + SLOT + imm_ext;
    end
endmodule

// File: rtl/nct_vec_class.sv
// Classifies a software-interrupt vector as processor-reserved (below
// RSV_VECTORS) or software-defined. Combinational.
module nct_vec_class #(
    parameter int VEC_W       = 8,
    parameter int RSV_VECTORS = 32
) (
    input  logic [VEC_W-1:0] vec,
    output logic             reserved,
    output logic             user
);
    localparam logic [VEC_W:0] LIMIT = (VEC_W+1)'(RSV_VECTORS);

    // Range compare with one spare bit so the limit may equal 2^VEC_W.
    always_comb begin
        reserved = ({1'b0, vec} < LIMIT);
        user     = !reserved;
    end
endmodule

// File: rtl/nct_ctl_fsm.sv
// Sequencing state machine. Accepts one operation when idle, performs the
// indirect-target read, the push or the pop on the memory port (request held
// until ack), then raises done for one cycle with the result registers.
// Assumes mem_rdata is valid in the cycle mem_ack is high.
module nct_ctl_fsm
    import nct_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic              cond_true,
    input  logic              ind_from_mem,
    input  logic [ADDR_W-1:0] ind_reg,
    input  logic [ADDR_W-1:0] ind_addr,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] rel_tgt,
    input  logic [ADDR_W-1:0] sp_dec,
    input  logic [ADDR_W-1:0] sp_ret,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ip_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata
);
    nct_state_e        state;
    nct_op_e           kind;
    nct_op_e           kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wdata_q;
    logic [ADDR_W-1:0] ip_q;
    logic [ADDR_W-1:0] sp_q;

    // Interpret the raw operation code.
    always_comb kind = nct_op_e'(op_kind);

    // State, access address and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= OP_JCC;
            addr_q  <= '0;
            wdata_q <= '0;
            ip_q    <= '0;
            sp_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (op_valid) begin
                        kind_q <= kind;
                        case (kind)
                            OP_JCC: begin
                                ip_q  <= cond_true ? rel_tgt : next_ip;
                                sp_q  <= sp_in;
                                state <= ST_FIN;
                            end
                            OP_JMP_REL: begin
                                ip_q  <= rel_tgt;
                                sp_q  <= sp_in;
                                state <= ST_FIN;
                            end
                            OP_JMP_IND: begin
                                sp_q <= sp_in;
                                if (ind_from_mem) begin
                                    addr_q <= ind_addr;
                                    state  <= ST_FETCH_TGT;
                                end else begin
                                    ip_q  <= ind_reg;
                                    state <= ST_FIN;
                                end
                            end
                            OP_CALL_REL: begin
                                ip_q    <= rel_tgt;
                                sp_q    <= sp_dec;
                                addr_q  <= sp_dec;
                                wdata_q <= next_ip;
                                state   <= ST_PUSH;
                            end
                            OP_CALL_IND: begin
                                sp_q    <= sp_dec;
                                wdata_q <= next_ip;
                                if (ind_from_mem) begin
                                    addr_q <= ind_addr;
                                    state  <= ST_FETCH_TGT;
                                end else begin
                                    ip_q   <= ind_reg;
                                    addr_q <= sp_dec;
                                    state  <= ST_PUSH;
                                end
                            end
                            OP_RET: begin
                                addr_q <= sp_in;
                                sp_q   <= sp_ret;
                                state  <= ST_POP;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_FETCH_TGT: begin
                    if (mem_ack) begin
                        ip_q <= mem_rdata;
                        if (kind_q == OP_CALL_IND) begin
                            addr_q <= sp_q;
                            state  <= ST_PUSH;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                ST_PUSH: begin
                    if (mem_ack) state <= ST_FIN;
                end
                ST_POP: begin
                    if (mem_ack) begin
                        ip_q  <= mem_rdata;
                        state <= ST_FIN;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode port controls and status from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        mem_req   = (state == ST_FETCH_TGT) || (state == ST_PUSH) || (state == ST_POP);
        mem_we    = (state == ST_PUSH);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        ip_out    = ip_q;
        sp_out    = sp_q;
    end
endmodule

// File: rtl/nct_seq.sv
// Top of the near control-transfer sequencer: address arithmetic, the
// sequencing state machine and the interrupt-vector classifier.
// Assumes the caller holds operands stable only in the accepting cycle.
module nct_seq #(
    parameter int ADDR_W      = 32,
    parameter int SHORT_W     = 8,
    parameter int IMM_W       = 16,
    parameter int SLOT_BYTES  = 4,
    parameter int VEC_W       = 8,
    parameter int RSV_VECTORS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic              op_long,
    input  logic [ADDR_W-1:0] op_disp,
    input  logic [IMM_W-1:0]  ret_imm,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic              cond_true,
    input  logic              ind_from_mem,
    input  logic [ADDR_W-1:0] ind_reg,
    input  logic [ADDR_W-1:0] ind_addr,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] new_ip,
    output logic [ADDR_W-1:0] new_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic [VEC_W-1:0]  int_vector,
    output logic              vec_reserved,
    output logic              vec_user
);
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] sp_dec;
    logic [ADDR_W-1:0] sp_ret;

    nct_addr_calc #(
        .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .IMM_W(IMM_W), .SLOT_BYTES(SLOT_BYTES)
    ) u_calc (
        .next_ip (next_ip),
        .disp    (op_disp),
        .is_long (op_long),
        .sp_in   (sp_in),
        .imm     (ret_imm),
        .rel_tgt (rel_tgt),
        .sp_dec  (sp_dec),
        .sp_ret  (sp_ret)
    );

    nct_ctl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_kind      (op_kind),
        .cond_true    (cond_true),
        .ind_from_mem (ind_from_mem),
        .ind_reg      (ind_reg),
        .ind_addr     (ind_addr),
        .next_ip      (next_ip),
        .sp_in        (sp_in),
        .rel_tgt      (rel_tgt),
        .sp_dec       (sp_dec),
        .sp_ret       (sp_ret),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .ip_out       (new_ip),
        .sp_out       (new_sp),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata)
    );

    nct_vec_class #(.VEC_W(VEC_W), .RSV_VECTORS(RSV_VECTORS)) u_vec (
        .vec      (int_vector),
        .reserved (vec_reserved),
        .user     (vec_user)
    );
endmodule

// File: rtl/nct_seq_chk.sv
// Protocol checker for nct_seq, bound to every instance of the top module.
module nct_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              vec_reserved,
    input logic              vec_user
);
    // R9: done lasts exactly one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an idle block neither requests memory nor reports completion.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    // R9: a request is held, unchanged, until acknowledged.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: completion is never reported with an access still open.
    a_r9_done_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R6 / R7: the push is the last access of a call, so done follows it.
    a_r7_push_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> done);

    // R10: exactly one vector class is reported.
    a_r10_vec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({vec_reserved, vec_user}));
endmodule

bind nct_seq nct_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .vec_reserved (vec_reserved),
    .vec_user     (vec_user)
);

// File: tb/nct_seq_tb.sv
module nct_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic        op_long = 1'b0;
    logic [31:0] op_disp = '0;
    logic [15:0] ret_imm = '0;
    logic [31:0] next_ip = '0;
    logic        cond_true = 1'b0;
    logic        ind_from_mem = 1'b0;
    logic [31:0] ind_reg = '0;
    logic [31:0] ind_addr = '0;
    logic [31:0] sp_in = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] new_ip, new_sp, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  int_vector = '0;
    logic        vec_reserved, vec_user;

    always #5 clk = ~clk;

    nct_seq u_dut (.*);

    // Bench memory: 16 words, addressed by bits 5..2.
    logic [31:0] store [16];
    int          txn_total = 0;
    logic        log_we   [8];
    logic [31:0] log_addr [8];
    int          done_cnt = 0;
    int          checks = 0;
    int          fails = 0;

    always @(negedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= store[mem_addr[5:2]];
        if (done) done_cnt <= done_cnt + 1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) store[i] <= 32'hC0DE_0000 ^ (i << 4);
        end else if (mem_req && mem_ack) begin
            if (mem_we) store[mem_addr[5:2]] <= mem_wdata;
            log_we[txn_total % 8]   <= mem_we;
            log_addr[txn_total % 8] <= mem_addr;
            txn_total <= txn_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    logic [31:0] got_ip, got_sp;
    int          t0, d0;

    // Issue one operation and wait for its done pulse.
    task automatic run_op(input logic [2:0] k, input logic lng, input logic [31:0] d,
                          input logic [15:0] imm, input logic [31:0] nip, input logic c,
                          input logic fm, input logic [31:0] rg, input logic [31:0] ia,
                          input logic [31:0] sp);
        bit seen = 0;
        @(negedge clk);
        t0 = txn_total; d0 = done_cnt;
        op_kind = k; op_long = lng; op_disp = d; ret_imm = imm; next_ip = nip;
        cond_true = c; ind_from_mem = fm; ind_reg = rg; ind_addr = ia; sp_in = sp;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done) begin
                seen = 1; got_ip = new_ip; got_sp = new_sp;
                break;
            end
            @(negedge clk);
        end
        chk(seen, "R9 done seen", 32'(seen), 32'd1);
    endtask

    function automatic logic [31:0] sx8(input logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] e, old;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req, "R1 reset", {busy, done, mem_req}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 after release", {busy, done, mem_req}, 32'd0);

        // R2 / R4: every short displacement, condition true and false, junk upper bits
        for (int dv = 0; dv < 256; dv++) begin
            for (int c = 0; c < 2; c++) begin
                run_op(3'd0, 1'b0, {24'hA5C3E1, 8'(dv)}, 16'h0, 32'h0000_8000 + dv, c[0], 0, 0, 0, 32'h0000_1000);
                e = c[0] ? (32'h0000_8000 + dv + sx8(8'(dv))) : (32'h0000_8000 + dv);
                chk(got_ip == e, c[0] ? "R2 short taken" : "R4 not taken", got_ip, e);
                chk(got_sp == 32'h0000_1000, "R4 sp unchanged", got_sp, 32'h0000_1000);
            end
        end
        // R4 unconditional jump ignores cond_true
        run_op(3'd1, 1'b0, 32'h0000_00F0, 0, 32'h100, 1'b0, 0, 0, 0, 32'h2000);
        chk(got_ip == 32'h0F0, "R4 jmp taken cond=0", got_ip, 32'h0F0);
        // R3 long, wrap both ways
        run_op(3'd1, 1'b1, 32'h0000_0020, 0, 32'hFFFF_FFF0, 1'b0, 0, 0, 0, 32'h2000);
        chk(got_ip == 32'h10, "R3 wrap up", got_ip, 32'h10);
        run_op(3'd0, 1'b1, 32'hFFFF_FFE0, 0, 32'h10, 1'b1, 0, 0, 0, 32'h2000);
        chk(got_ip == 32'hFFFF_FFF0, "R3 wrap down", got_ip, 32'hFFFF_FFF0);
        run_op(3'd1, 1'b1, 32'h1234_0000, 0, 32'h0000_5678, 1'b0, 0, 0, 0, 32'h2000);
        chk(got_ip == 32'h1234_5678, "R3 long far", got_ip, 32'h1234_5678);
        // R5 indirect jump, register and memory
        run_op(3'd2, 0, 0, 0, 32'h40, 0, 1'b0, 32'hDEAD_BEE0, 0, 32'h3000);
        chk(got_ip == 32'hDEAD_BEE0 && got_sp == 32'h3000, "R5 reg ind", got_ip, 32'hDEAD_BEE0);
        e = store[5];
        run_op(3'd2, 0, 0, 0, 32'h40, 0, 1'b1, 32'h1, 32'h0000_0014, 32'h3000);
        chk(got_ip == e && got_sp == 32'h3000, "R5 mem ind", got_ip, e);
        chk(txn_total - t0 == 1 && log_we[t0 % 8] == 0 && log_addr[t0 % 8] == 32'h14, "R5 one read", txn_total - t0, 1);
        // R6 relative call
        run_op(3'd3, 1'b0, 32'h10, 0, 32'h0000_0500, 0, 0, 0, 0, 32'h0000_0028);
        chk(got_ip == 32'h510 && got_sp == 32'h24, "R6 call ip/sp", got_ip, 32'h510);
        chk(store[9] == 32'h500 && log_we[t0 % 8] && log_addr[t0 % 8] == 32'h24, "R6 push", store[9], 32'h500);
        // R6 register indirect call
        run_op(3'd4, 0, 0, 0, 32'h0000_0777, 0, 1'b0, 32'hCAFE_0000, 0, 32'h0000_0030);
        chk(got_ip == 32'hCAFE_0000 && got_sp == 32'h2C && store[11] == 32'h777, "R6 ind call", got_ip, 32'hCAFE_0000);
        // R7 memory indirect call where target word is the push slot
        old = store[3];
        run_op(3'd4, 0, 0, 0, 32'h0000_0999, 0, 1'b1, 0, 32'h0000_000C, 32'h0000_0010);
        chk(got_ip == old, "R7 read sees old", got_ip, old);
        chk(txn_total - t0 == 2 && !log_we[t0 % 8] && log_we[(t0 + 1) % 8], "R7 order", {log_we[t0 % 8], log_we[(t0 + 1) % 8]}, 32'h1);
        chk(store[3] == 32'h999 && got_sp == 32'hC, "R7 push done", store[3], 32'h999);
        // R8 returns across the immediate range
        for (int im = 0; im < 65536; im += 257) begin
            e = store[(im / 257) % 16];
            run_op(3'd5, 0, 0, 16'(im), 0, 0, 0, 0, 0, 32'(((im / 257) % 16) * 4));
            chk(got_ip == e, "R8 ret ip", got_ip, e);
            chk(got_sp == 32'(((im / 257) % 16) * 4 + 4 + im), "R8 ret sp", got_sp, 32'(((im / 257) % 16) * 4 + 4 + im));
        end
        run_op(3'd5, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 32'hFFFF_0000);
        chk(got_sp == 32'h0000_0003, "R8 max imm wrap", got_sp, 32'h3);
        // R9 request while busy is ignored, exactly one done
        @(negedge clk);
        d0 = done_cnt;
        op_kind = 3'd3; op_long = 0; op_disp = 32'h4; next_ip = 32'h600; sp_in = 32'h20; op_valid = 1'b1;
        @(negedge clk);
        op_kind = 3'd1; op_disp = 32'h7F; next_ip = 32'h1000;
        @(negedge clk);
        chk(busy, "R9 busy", 32'(busy), 32'd1);
        @(negedge clk); op_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);
        chk(new_ip == 32'h604 && new_sp == 32'h1C, "R9 busy ignore", new_ip, 32'h604);
        chk(!busy && !mem_req, "R9 idle after", {busy, mem_req}, 0);
        // R10 every vector
        for (int v = 0; v < 256; v++) begin
            int_vector = 8'(v);
            #1;
            chk(vec_reserved == (v < 32) && vec_user == (v >= 32), "R10 vector", {vec_reserved, vec_user}, (v < 32) ? 2 : 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule